// File: doc/BRIEF.md
# Programmable Serial Bit Clock Generator

This block produces the bit clock for a serial port from the core clock. The internal path is a chain of dividers: a fixed halving stage, then a prescaler that divides by 1 or 8, then a modulus counter that divides by 1 to 256. The result toggles a 50%-duty level. A direction input selects the source. When the serial clock pin is an output, the generated level is driven to it. When the pin is an input, the clock arriving on the pin is synchronised into the core domain and used in place of the generated one.

The shift and framing logic downstream works only in the core clock domain. To serve it, the block gives a one-cycle enable for each rising and each falling bit-clock edge, together with the bit-clock level itself. The divider controls may be rewritten at any time. A new setting is captured only when the current half-period ends, so no shortened pulse ever reaches the pin.

Top module: `sbclk_gen`

## Requirements
- R1: While reset is held and in the cycle after it is released, `bclk_out`, `rise_en` and `fall_en` are 0, and `bclk_oe` equals `pin_is_output`.
- R2: In internal mode, each half-period of the bit clock lasts 2·P·M core cycles. P is 1 when `pre_x8` is 0 and 8 when it is 1. M is `modulus`+1.
- R3: The fastest setting (`pre_x8`=0, `modulus`=0) gives a half-period of 2 core cycles, which is a bit clock of one quarter of the core rate.
- R4: The slowest setting (`pre_x8`=1, `modulus`=255) gives a half-period of 4096 core cycles.
- R5: Divider settings are sampled only at the end of each half-period. A half-period already in progress finishes with the settings that were in force when it began.
- R6: `rise_en` is high for exactly the first core cycle in which `bclk_out` is 1, and `fall_en` for exactly the first core cycle in which it is 0. In internal mode, rising and falling edges alternate.
- R7: `rise_en` and `fall_en` are never high together. In internal mode, two edge enables are never high in consecutive cycles.
- R8: In external mode (`pin_is_output`=0), a change of `ext_bclk` appears on `bclk_out` after the second rising core-clock edge following the change. The matching enable is high for that one cycle.
- R9: In external mode, `bclk_oe` is 0, and while `ext_bclk` is steady no edge enable is produced, whatever the internal divider is doing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_is_output | input | 1 | 1: drive generated clock to pin; 0: take clock from pin |
| pre_x8 | input | 1 | Prescaler range: 0 divides by 1, 1 divides by 8 |
| modulus | input | MOD_W | Modulus field N, divides by N+1 |
| ext_bclk | input | 1 | Bit clock arriving on the pin (asynchronous) |
| bclk_out | output | 1 | Bit clock level (generated or synchronised) |
| bclk_oe | output | 1 | Pin output enable |
| rise_en | output | 1 | One-cycle pulse on each rising bit-clock edge |
| fall_en | output | 1 | One-cycle pulse on each falling bit-clock edge |

## Verification
The bench measures every half-period and compares it with 2·P·M. It rewrites the settings right after an edge, so a design that applied them at once would shorten the running half-period, and the mismatch would show as a wrong length on that interval rather than the next. Both extremes are driven: the two-cycle half-period catches an off-by-one in the N+1 modulus or a missing halving stage, and the 4096-cycle half-period catches a prescaler that is too narrow or that wraps. External mode is checked for the exact two-edge synchroniser latency, and for silence while the pin is idle, which a design still leaking internal edges would break.

// File: rtl/sbclk_gen.sv
module sbclk_gen #(
  parameter int MOD_W = 8,
  parameter int PRE_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_is_output,
  input  logic             pre_x8,
  input  logic [MOD_W-1:0] modulus,
  input  logic             ext_bclk,
  output logic             bclk_out,
  output logic             bclk_oe,
  output logic             rise_en,
  output logic             fall_en
);

  logic             half;
  logic [PRE_W-1:0] pre_cnt;
  logic [MOD_W-1:0] mod_cnt;
  logic [MOD_W-1:0] act_mod;
  logic             act_x8;
  logic             gen, gen_rise, gen_fall;
  logic [2:0]       sync;

  wire pre_tc = act_x8 ? (pre_cnt == {PRE_W{1'b1}}) : 1'b1;
  wire mod_tc = (mod_cnt == act_mod);
  wire term   = half & pre_tc & mod_tc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      half     <= 1'b0;
      pre_cnt  <= '0;
      mod_cnt  <= '0;
      act_mod  <= '0;
      act_x8   <= 1'b0;
      gen      <= 1'b0;
      gen_rise <= 1'b0;
      gen_fall <= 1'b0;
      sync     <= '0;
    end else begin
      half     <= ~half;
      gen_rise <= term & ~gen;
      gen_fall <= term & gen;
      sync     <= {sync[1:0], ext_bclk};
      if (term) begin
        gen     <= ~gen;
        pre_cnt <= '0;
        mod_cnt <= '0;
        act_x8  <= pre_x8;
        act_mod <= modulus;
      end else if (half) begin
        if (pre_tc) begin
          pre_cnt <= '0;
          mod_cnt <= mod_cnt + 1'b1;
        end else begin
          pre_cnt <= pre_cnt + 1'b1;
        end
      end
    end
  end

  assign bclk_oe  = pin_is_output;
  assign bclk_out = pin_is_output ? gen      : sync[1];
  assign rise_en  = pin_is_output ? gen_rise : (sync[1] & ~sync[2]);
  assign fall_en  = pin_is_output ? gen_fall : (~sync[1] & sync[2]);

endmodule

// File: rtl/sbclk_gen_chk.sv
module sbclk_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic pin_is_output,
  input logic bclk_out,
  input logic rise_en,
  input logic fall_en
);

  assert_no_overlap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_en && fall_en));

  assert_rise_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_en && pin_is_output && $past(pin_is_output)) |-> (bclk_out && !$past(bclk_out)));

  assert_fall_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_en && pin_is_output && $past(pin_is_output)) |-> (!bclk_out && $past(bclk_out)));

  assert_quiet_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!rise_en && !fall_en && pin_is_output && $past(pin_is_output)) |-> $stable(bclk_out));

  assert_min_spacing_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((rise_en || fall_en) && pin_is_output) |=> !(pin_is_output && (rise_en || fall_en)));

endmodule

bind sbclk_gen sbclk_gen_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .pin_is_output(pin_is_output),
  .bclk_out     (bclk_out),
  .rise_en      (rise_en),
  .fall_en      (fall_en)
);

// File: tb/sbclk_gen_tb.sv
`timescale 1ns/1ps
module sbclk_gen_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pin_is_output = 1'b1;
  logic       pre_x8 = 1'b0;
  logic [7:0] modulus = 8'd0;
  logic       ext_bclk = 1'b0;
  logic       bclk_out, bclk_oe, rise_en, fall_en;

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  always #4 clk = ~clk;

  sbclk_gen u_dut (
    .clk(clk), .rst_n(rst_n), .pin_is_output(pin_is_output), .pre_x8(pre_x8),
    .modulus(modulus), .ext_bclk(ext_bclk), .bclk_out(bclk_out), .bclk_oe(bclk_oe),
    .rise_en(rise_en), .fall_en(fall_en)
  );

  function automatic int half_len(input logic x8, input logic [7:0] m);
    return 2 * (x8 ? 8 : 1) * (int'(m) + 1);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  logic last_was_rise;

  task automatic next_edge(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!(rise_en || fall_en) && n < 20000);
  endtask

  task automatic measure(input string req, input int exp);
    int n;
    next_edge(n);
    check(req, n, exp);
    check("R6", int'(bclk_out), int'(rise_en));
    check("R6", int'(rise_en), int'(!last_was_rise));
    last_was_rise = rise_en;
  endtask

  initial begin
    int exp;
    int n;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    check("R1", int'({bclk_out, rise_en, fall_en}), 0);
    check("R1", int'(bclk_oe), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", int'({bclk_out, rise_en, fall_en}), 0);

    next_edge(n);
    check("R6", int'(rise_en), 1);
    last_was_rise = 1'b1;
    exp = half_len(pre_x8, modulus);

    // R3 fastest
    repeat (4) measure("R3", exp);

    // R5: change right after an edge; running half keeps old length
    modulus = 8'd5;
    measure("R5", exp);
    exp = half_len(pre_x8, modulus);
    measure("R2", exp);
    pre_x8 = 1'b1; modulus = 8'd2;
    measure("R5", exp);
    exp = half_len(pre_x8, modulus);
    measure("R2", exp);

    // random settings
    for (int i = 0; i < 40; i++) begin
      if ($urandom_range(0, 2) != 0) begin
        pre_x8  = 1'($urandom_range(0, 1));
        modulus = pre_x8 ? 8'($urandom_range(0, 15)) : 8'($urandom_range(0, 255));
      end
      measure("R5", exp);
      exp = half_len(pre_x8, modulus);
    end
    measure("R2", exp);

    // R4 slowest
    pre_x8 = 1'b1; modulus = 8'd255;
    measure("R5", exp);
    exp = half_len(pre_x8, modulus);
    check("R4", exp, 4096);
    measure("R4", exp);
    pre_x8 = 1'b0; modulus = 8'd0;
    measure("R4", exp);

    // external mode
    @(negedge clk);
    pin_is_output = 1'b0;
    ext_bclk = 1'b0;
    repeat (4) @(negedge clk);
    check("R9", int'(bclk_oe), 0);
    begin
      int seen = 0;
      repeat (60) begin
        @(negedge clk);
        if (rise_en || fall_en) seen++;
      end
      check("R9", seen, 0);
    end
    for (int k = 0; k < 6; k++) begin
      ext_bclk = ~ext_bclk;
      @(negedge clk);
      check("R8", int'({rise_en, fall_en}), 0);
      @(negedge clk);
      check("R8", int'(bclk_out), int'(ext_bclk));
      check("R8", int'(rise_en), int'(ext_bclk));
      check("R8", int'(fall_en), int'(!ext_bclk));
      @(negedge clk);
      check("R8", int'({rise_en, fall_en}), 0);
      repeat ($urandom_range(0, 3)) @(negedge clk);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule